// File: doc/BRIEF.md
# Card Data Byte FIFO Engine

This block sits between a processor register port and the byte-wide data path of a memory card controller. It buffers bytes in both directions. Outbound bytes go into a transmit ring of 64 bytes, used one 32-byte half at a time. Inbound bytes go into a 32-byte receive ring. A transfer begins with a pulse on `xfer_start`. The pulse loads a down-counter with block length times block count and empties both rings. The counter drops by one for each byte that crosses the card-side handshake. When it reaches zero the engine goes idle and raises completion flags.

Processor accesses are 1, 2 or 4 bytes wide. Bytes are packed most significant lane first. Sending commands, signalling on the card bus and computing CRC belong to neighbouring blocks. The card side is a plain valid/ready byte stream in each direction. At most one byte crosses each stream per clock.

Top module: `cdf_engine`

## Requirements
- R1: After reset no transfer is active. `card_tx_valid`, `card_rx_ready`, `tx_req`, `rx_req`, `data_done` and `prog_done` are low, and `cpu_rdata` is zero.
- R2: A write to select 1 (transmit data) of size N queues N bytes. The size code is 0 for 1 byte, 1 for 2 bytes, and 2 or 3 for 4 bytes. The first byte queued is taken from the most significant lane of the N-byte word. Bytes leave on `card_tx_data` in the order they were queued. Bytes offered while 32 are already queued are dropped.
- R3: A read of select 0 (receive data) of size N removes up to N bytes. The oldest byte lands in the most significant lane of the N-byte word. Lanes that have no byte because the ring ran empty read as zero.
- R4: The receive ring holds 32 bytes. `card_rx_ready` is low while 32 bytes are held.
- R5: After `xfer_start`, exactly block length × block count bytes cross the card handshake in the selected direction. After that, no further byte is offered or accepted. A total of zero completes without moving any byte.
- R6: When the count reaches zero, `active` falls and `data_done` rises. `prog_done` also rises, but only in write direction. Select 7 reads these flags: bit 0 is active, bit 11 is data done and bit 12 is program done.
- R7: `tx_req` is high while a write-direction transfer still has bytes to move. It stays high after completion until a write to select 1 clears it.
- R8: `rx_req` rises when a byte arrives from the card. A read of select 0 in a cycle with no arrival clears it.
- R9: A write to select 2 with bit 0 set switches the transmit half and discards every queued transmit byte. With bit 0 clear the write has no effect.
- R10: Select 3 holds a 12-bit block length and select 4 a 16-bit block count. Select 5 reads back the block count, and writes to it are ignored. Select 6 holds the direction in bit 3, where 1 means write to the card. These registers keep only those bits.
- R11: At most one byte moves per clock in each direction, and only one direction is enabled at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_start | input | 1 | Load byte count, empty rings, begin transfer |
| cpu_req | input | 1 | Register access strobe |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_sel | input | 3 | Register select |
| cpu_size | input | 2 | Access size code |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, registered one clock after the access |
| card_tx_valid | output | 1 | Outbound byte offered |
| card_tx_ready | input | 1 | Card takes outbound byte |
| card_tx_data | output | 8 | Outbound byte |
| card_rx_valid | input | 1 | Inbound byte offered |
| card_rx_ready | output | 1 | Engine takes inbound byte |
| card_rx_data | input | 8 | Inbound byte |
| tx_req | output | 1 | Transmit service request |
| rx_req | output | 1 | Receive service request |
| active | output | 1 | Transfer in progress |
| data_done | output | 1 | Byte count exhausted |
| prog_done | output | 1 | Byte count exhausted in write direction |

## Verification
The hardest state to reach is a full receive ring with bytes still owed. This is the only time `card_rx_ready` drops while the counter is nonzero. The stimulus streams 35 inbound bytes with no reads in between, so the ring fills and the handshake stalls. Randomly sized reads then free room, and the remaining bytes finish the count. The last reads ask for more bytes than remain, which exposes the zero lanes. On the transmit side, random-width writes overfill the queue past 32 bytes before any byte drains, so the drop rule is checked byte by byte.

// File: rtl/cdf_pkg.sv
package cdf_pkg;

    typedef enum logic [2:0] {
        SEL_RXDATA  = 3'd0,
        SEL_TXDATA  = 3'd1,
        SEL_PARTIAL = 3'd2,
        SEL_BLKLEN  = 3'd3,
        SEL_NUMBLK  = 3'd4,
        SEL_BLKREM  = 3'd5,
        SEL_CTRL    = 3'd6,
        SEL_STATUS  = 3'd7
    } cdf_sel_e;

    localparam int LANES         = 4;
    localparam int LCW           = $clog2(LANES + 1);
    localparam int DIR_BIT       = 3;
    localparam int ST_ACTIVE_BIT = 0;
    localparam int ST_DDONE_BIT  = 11;
    localparam int ST_PDONE_BIT  = 12;

    // Byte count of an access from its size code.
    function automatic logic [LCW-1:0] size_bytes(input logic [1:0] code);
        case (code)
            2'd0:    size_bytes = LCW'(1);
            2'd1:    size_bytes = LCW'(2);
            default: size_bytes = LCW'(4);
        endcase
    endfunction

    // Bit offset of the k-th moved byte in an n-byte word (first byte highest).
    function automatic int lane_shift(input int n, input int k);
        lane_shift = (n - 1 - k) * 8;
    endfunction

endpackage

// File: rtl/cdf_byte_ring.sv
module cdf_byte_ring #(
    parameter int DEPTH    = 32,
    parameter int BANKS    = 1,
    parameter int PUSH_MAX = 1,
    parameter int POP_MAX  = 1,
    localparam int AW  = $clog2(DEPTH),
    localparam int CW  = AW + 1,
    localparam int SW  = $clog2(BANKS * DEPTH),
    localparam int PCW = $clog2(PUSH_MAX + 1),
    localparam int OCW = $clog2(POP_MAX + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  flip,
    input  logic [PCW-1:0]        push_cnt,
    input  logic [PUSH_MAX*8-1:0] push_data,
    input  logic [OCW-1:0]        pop_cnt,
    output logic [CW-1:0]         count,
    output logic [POP_MAX*8-1:0]  peek
);

    typedef struct packed {
        logic          bank;
        logic [AW-1:0] head;
        logic [CW-1:0] len;
    } ring_st_t;

    ring_st_t   st_d, st_q;
    logic [7:0] mem_d [BANKS*DEPTH];
    logic [7:0] mem_q [BANKS*DEPTH];
    logic       flip_eff;

    generate
        if (BANKS > 1) begin : g_banked
            assign flip_eff = flip;
        end else begin : g_single
            assign flip_eff = 1'b0;
        end
    endgenerate

    function automatic logic [SW-1:0] slot(input logic bank, input logic [AW-1:0] off);
        slot = SW'(off) | (SW'(bank) << AW);
    endfunction

    always_comb begin
        st_d  = st_q;
        mem_d = mem_q;
        for (int k = 0; k < PUSH_MAX; k++) begin
            if (k < int'(push_cnt)) begin
                mem_d[slot(st_q.bank, st_q.head + AW'(st_q.len) + AW'(k))] = push_data[k*8 +: 8];
            end
        end
        st_d.head = st_q.head + AW'(pop_cnt);
        st_d.len  = st_q.len + CW'(push_cnt) - CW'(pop_cnt);
        if (clear || flip_eff) begin
            st_d.len = '0;
        end
        if (flip_eff) begin
            st_d.bank = ~st_q.bank;
        end
    end

    always_comb begin
        for (int k = 0; k < POP_MAX; k++) begin
            peek[k*8 +: 8] = mem_q[slot(st_q.bank, st_q.head + AW'(k))];
        end
    end

    assign count = st_q.len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < BANKS * DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            st_q  <= st_d;
            mem_q <= mem_d;
        end
    end

    p_ring_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.len <= CW'(DEPTH));

    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        CW'(pop_cnt) <= st_q.len);

    p_flip_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flip_eff |=> (st_q.len == '0) && (st_q.bank != $past(st_q.bank)));

endmodule

// File: rtl/cdf_xfer_count.sv
module cdf_xfer_count #(
    parameter int CNT_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] total,
    input  logic             dir_wr,
    input  logic             step,
    output logic             active,
    output logic             rem_nz,
    output logic             busy_next,
    output logic             data_done,
    output logic             prog_done
);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] rem;
        logic             ddone;
        logic             pdone;
    } cnt_st_t;

    cnt_st_t          st_d, st_q;
    logic [CNT_W-1:0] rem_after;

    always_comb begin
        st_d      = st_q;
        rem_after = st_q.rem - CNT_W'(step);
        if (start) begin
            st_d.active = 1'b1;
            st_d.rem    = total;
            st_d.ddone  = 1'b0;
            st_d.pdone  = 1'b0;
        end else if (st_q.active) begin
            st_d.rem = rem_after;
            if (rem_after == '0) begin
                st_d.active = 1'b0;
                st_d.ddone  = 1'b1;
                st_d.pdone  = dir_wr;
            end
        end
    end

    assign active    = st_q.active;
    assign rem_nz    = (st_q.rem != '0);
    assign busy_next = st_d.active && (st_d.rem != '0);
    assign data_done = st_q.ddone;
    assign prog_done = st_q.pdone;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_step_one_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && step && !start) |=> (st_q.rem == $past(st_q.rem) - CNT_W'(1)));

    p_step_needs_work_r5: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (st_q.active && st_q.rem != '0));

    p_prog_implies_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pdone |-> st_q.ddone);

    p_done_is_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ddone |-> !st_q.active);

endmodule

// File: rtl/cdf_engine.sv
module cdf_engine
    import cdf_pkg::*;
#(
    parameter int RX_DEPTH = 32,
    parameter int TX_DEPTH = 32,
    parameter int BLKLEN_W = 12,
    parameter int NUMBLK_W = 16,
    localparam int CNT_W   = BLKLEN_W + NUMBLK_W,
    localparam int RX_CW   = $clog2(RX_DEPTH) + 1,
    localparam int TX_CW   = $clog2(TX_DEPTH) + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        xfer_start,
    input  logic        cpu_req,
    input  logic        cpu_we,
    input  logic [2:0]  cpu_sel,
    input  logic [1:0]  cpu_size,
    input  logic [31:0] cpu_wdata,
    output logic [31:0] cpu_rdata,
    output logic        card_tx_valid,
    input  logic        card_tx_ready,
    output logic [7:0]  card_tx_data,
    input  logic        card_rx_valid,
    output logic        card_rx_ready,
    input  logic [7:0]  card_rx_data,
    output logic        tx_req,
    output logic        rx_req,
    output logic        active,
    output logic        data_done,
    output logic        prog_done
);

    typedef struct packed {
        logic [BLKLEN_W-1:0] blklen;
        logic [NUMBLK_W-1:0] numblk;
        logic                dir_wr;
        logic                rx_req;
        logic                tx_req;
        logic [31:0]         rdata;
    } eng_st_t;

    eng_st_t            st_d, st_q;

    logic [LCW-1:0]     nbytes;
    logic               rd_acc, wr_acc, rx_acc, tx_acc, flip;
    logic [RX_CW-1:0]   rx_count;
    logic [TX_CW-1:0]   tx_count, tx_room;
    logic [LCW-1:0]     rx_pop, tx_push;
    logic [LANES*8-1:0] rx_peek, tx_pdata;
    logic [31:0]        rx_word;
    logic               rx_push, tx_pop, step;
    logic               cnt_active, cnt_rem_nz, cnt_busy_next;

    assign nbytes = size_bytes(cpu_size);
    assign rd_acc = cpu_req && !cpu_we;
    assign wr_acc = cpu_req && cpu_we;
    assign rx_acc = rd_acc && (cdf_sel_e'(cpu_sel) == SEL_RXDATA);
    assign tx_acc = wr_acc && (cdf_sel_e'(cpu_sel) == SEL_TXDATA);
    assign flip   = wr_acc && (cdf_sel_e'(cpu_sel) == SEL_PARTIAL) && cpu_wdata[0];

    // Card-side handshakes depend on registered state only (plus start gating).
    assign card_rx_ready = cnt_active && !st_q.dir_wr && cnt_rem_nz && !xfer_start
                           && (rx_count < RX_CW'(RX_DEPTH));
    assign card_tx_valid = cnt_active && st_q.dir_wr && cnt_rem_nz && !xfer_start
                           && (tx_count != '0);
    assign rx_push = card_rx_ready && card_rx_valid;
    assign tx_pop  = card_tx_valid && card_tx_ready;
    assign step    = rx_push || tx_pop;

    // CPU-side byte counts, limited by occupancy before this cycle.
    assign rx_pop  = rx_acc ? ((rx_count < RX_CW'(nbytes)) ? LCW'(rx_count) : nbytes) : '0;
    assign tx_room = TX_CW'(TX_DEPTH) - tx_count;
    assign tx_push = tx_acc ? ((tx_room < TX_CW'(nbytes)) ? LCW'(tx_room) : nbytes) : '0;

    // Unpack write word: first byte from the highest lane of the access.
    always_comb begin
        tx_pdata = '0;
        for (int k = 0; k < LANES; k++) begin
            if (k < int'(nbytes)) begin
                tx_pdata[k*8 +: 8] = cpu_wdata[lane_shift(int'(nbytes), k) +: 8];
            end
        end
    end

    // Pack read word: oldest byte to the highest lane, missing lanes zero.
    always_comb begin
        rx_word = '0;
        for (int k = 0; k < LANES; k++) begin
            if (k < int'(rx_pop)) begin
                rx_word[lane_shift(int'(nbytes), k) +: 8] = rx_peek[k*8 +: 8];
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (wr_acc) begin
            case (cdf_sel_e'(cpu_sel))
                SEL_BLKLEN: st_d.blklen = cpu_wdata[BLKLEN_W-1:0];
                SEL_NUMBLK: st_d.numblk = cpu_wdata[NUMBLK_W-1:0];
                SEL_CTRL:   st_d.dir_wr = cpu_wdata[DIR_BIT];
                default:    ;
            endcase
        end
        if (rd_acc) begin
            case (cdf_sel_e'(cpu_sel))
                SEL_RXDATA: st_d.rdata = rx_word;
                SEL_BLKLEN: st_d.rdata = 32'(st_q.blklen);
                SEL_NUMBLK: st_d.rdata = 32'(st_q.numblk);
                SEL_BLKREM: st_d.rdata = 32'(st_q.numblk);
                SEL_CTRL:   st_d.rdata = 32'(st_q.dir_wr) << DIR_BIT;
                SEL_STATUS: st_d.rdata = (32'(cnt_active) << ST_ACTIVE_BIT)
                                       | (32'(data_done)  << ST_DDONE_BIT)
                                       | (32'(prog_done)  << ST_PDONE_BIT);
                default:    st_d.rdata = '0;
            endcase
        end
        st_d.rx_req = (rx_acc ? 1'b0 : st_q.rx_req) || rx_push;
        st_d.tx_req = (tx_acc ? 1'b0 : st_q.tx_req) || (cnt_busy_next && st_q.dir_wr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    cdf_byte_ring #(
        .DEPTH(RX_DEPTH), .BANKS(1), .PUSH_MAX(1), .POP_MAX(LANES)
    ) rx_ring_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (xfer_start),
        .flip     (1'b0),
        .push_cnt (rx_push),
        .push_data(card_rx_data),
        .pop_cnt  (rx_pop),
        .count    (rx_count),
        .peek     (rx_peek)
    );

    cdf_byte_ring #(
        .DEPTH(TX_DEPTH), .BANKS(2), .PUSH_MAX(LANES), .POP_MAX(1)
    ) tx_ring_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (xfer_start),
        .flip     (flip),
        .push_cnt (tx_push),
        .push_data(tx_pdata),
        .pop_cnt  (tx_pop),
        .count    (tx_count),
        .peek     (card_tx_data)
    );

    cdf_xfer_count #(
        .CNT_W(CNT_W)
    ) count_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (xfer_start),
        .total    (CNT_W'(st_q.blklen) * CNT_W'(st_q.numblk)),
        .dir_wr   (st_q.dir_wr),
        .step     (step),
        .active   (cnt_active),
        .rem_nz   (cnt_rem_nz),
        .busy_next(cnt_busy_next),
        .data_done(data_done),
        .prog_done(prog_done)
    );

    assign cpu_rdata = st_q.rdata;
    assign rx_req    = st_q.rx_req;
    assign tx_req    = st_q.tx_req;
    assign active    = cnt_active;

    p_one_dir_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(card_rx_ready && card_tx_valid));

    p_rxreq_on_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |=> rx_req);

    p_txreq_clear_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_acc && !cnt_busy_next) |=> !tx_req);

endmodule

// File: tb/cdf_engine_tb_top.sv
module cdf_engine_tb_top;

    localparam logic [2:0] S_RX = 3'd0, S_TX = 3'd1, S_PART = 3'd2, S_BLKLEN = 3'd3,
                           S_NUMBLK = 3'd4, S_BLKREM = 3'd5, S_CTRL = 3'd6, S_STAT = 3'd7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_start = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [2:0]  cpu_sel = '0;
    logic [1:0]  cpu_size = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        card_tx_valid, card_tx_ready = 1'b0;
    logic [7:0]  card_tx_data;
    logic        card_rx_valid = 1'b0, card_rx_ready;
    logic [7:0]  card_rx_data = '0;
    logic        tx_req, rx_req, active, data_done, prog_done;

    int checks = 0;
    int fails  = 0;
    logic [7:0] txm[$];
    logic [7:0] rxm[$];
    logic [7:0] got[$];
    int rx_total;
    logic [7:0] next_rx;

    always #2 clk = ~clk;

    cdf_engine dut_i (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_sel(cpu_sel), .cpu_size(cpu_size),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .card_tx_valid(card_tx_valid), .card_tx_ready(card_tx_ready), .card_tx_data(card_tx_data),
        .card_rx_valid(card_rx_valid), .card_rx_ready(card_rx_ready), .card_rx_data(card_rx_data),
        .tx_req(tx_req), .rx_req(rx_req), .active(active),
        .data_done(data_done), .prog_done(prog_done)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int nb(input logic [1:0] code);
        return (code == 2'd0) ? 1 : (code == 2'd1) ? 2 : 4;
    endfunction

    // Model of a transmit write: first byte from highest lane, cap at 32.
    function automatic void tx_model(input logic [1:0] code, input logic [31:0] d);
        int n = nb(code);
        for (int k = 0; k < n; k++) begin
            if (txm.size() < 32) txm.push_back(d[(n-1-k)*8 +: 8]);
        end
    endfunction

    // Model of a receive read: oldest byte in highest lane, zero when empty.
    function automatic logic [31:0] rx_model(input logic [1:0] code);
        int n = nb(code);
        logic [31:0] w = '0;
        for (int k = 0; k < n; k++) begin
            if (rxm.size() > 0) w[(n-1-k)*8 +: 8] = rxm.pop_front();
        end
        return w;
    endfunction

    task automatic cpu_wr(input logic [2:0] sel, input logic [1:0] sz, input logic [31:0] d);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_sel = sel; cpu_size = sz; cpu_wdata = d;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic cpu_rd(input logic [2:0] sel, input logic [1:0] sz, output logic [31:0] d);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_sel = sel; cpu_size = sz;
        @(negedge clk);
        cpu_req = 1'b0;
        d = cpu_rdata;
    endtask

    task automatic start_xfer();
        xfer_start = 1'b1;
        @(negedge clk);
        xfer_start = 1'b0;
    endtask

    task automatic drain(input int n, input bit rnd);
        got.delete();
        for (int c = 0; c < 600 && got.size() < n; c++) begin
            card_tx_ready = rnd ? 1'($urandom % 2) : 1'b1;
            #1;
            if (card_tx_valid && card_tx_ready) got.push_back(card_tx_data);
            @(negedge clk);
        end
        card_tx_ready = 1'b0;
    endtask

    task automatic feed(input int cycles);
        for (int c = 0; c < cycles; c++) begin
            card_rx_valid = 1'b1;
            card_rx_data  = next_rx;
            #1;
            if (card_rx_ready) begin
                rxm.push_back(next_rx);
                next_rx++;
                rx_total++;
            end
            @(negedge clk);
        end
        card_rx_valid = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [7:0]  exp_b[$];
        void'($urandom(32'h5EED_CAFE));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(!card_tx_valid && !card_rx_ready && !tx_req && !rx_req, "R1 handshakes/requests idle",
            {card_tx_valid, card_rx_ready, tx_req, rx_req}, 32'd0);
        chk(!active && !data_done && !prog_done, "R1 flags idle", {active, data_done, prog_done}, 32'd0);
        chk(cpu_rdata == 32'd0, "R1 rdata", cpu_rdata, 32'd0);

        // R10 register widths and blocks-remaining
        cpu_wr(S_BLKLEN, 2'd2, 32'hFFFF_FFFF);
        cpu_rd(S_BLKLEN, 2'd2, rd);
        chk(rd == 32'h0000_0FFF, "R10 block length 12 bits", rd, 32'h0000_0FFF);
        cpu_wr(S_NUMBLK, 2'd2, 32'h000A_BCDE);
        cpu_wr(S_BLKREM, 2'd2, 32'h0000_1234);
        cpu_rd(S_NUMBLK, 2'd2, rd);
        chk(rd == 32'h0000_BCDE, "R10 block count 16 bits, remaining write ignored", rd, 32'h0000_BCDE);
        cpu_rd(S_BLKREM, 2'd2, rd);
        chk(rd == 32'h0000_BCDE, "R10 blocks remaining reads count", rd, 32'h0000_BCDE);
        cpu_wr(S_CTRL, 2'd2, 32'hFFFF_FFFF);
        cpu_rd(S_CTRL, 2'd2, rd);
        chk(rd == 32'h0000_0008, "R10 direction bit only", rd, 32'h0000_0008);

        // R2 R7 directed transmit, write direction, 10 bytes
        cpu_wr(S_BLKLEN, 2'd2, 32'd5);
        cpu_wr(S_NUMBLK, 2'd2, 32'd2);
        start_xfer();
        txm.delete();
        cpu_wr(S_TX, 2'd2, 32'hA1B2_C3D4); tx_model(2'd2, 32'hA1B2_C3D4);
        cpu_wr(S_TX, 2'd1, 32'hFFFF_1122); tx_model(2'd1, 32'hFFFF_1122);
        cpu_wr(S_TX, 2'd0, 32'hFFFF_FF33); tx_model(2'd0, 32'hFFFF_FF33);
        chk(tx_req, "R7 request while bytes remain", 32'(tx_req), 32'd1);
        chk(active && !data_done, "R5 active mid transfer", {active, data_done}, 32'h2);
        drain(7, 1'b0);
        exp_b = '{8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'h11, 8'h22, 8'h33};
        for (int i = 0; i < 7; i++)
            chk(got.size() > i && got[i] == exp_b[i], "R2 lane order", got.size() > i ? 32'(got[i]) : 32'hX, 32'(exp_b[i]));
        cpu_wr(S_TX, 2'd2, 32'h5566_7788);
        drain(3, 1'b0);
        chk(got.size() == 3 && got[0] == 8'h55 && got[2] == 8'h77, "R5 last bytes",
            got.size() == 3 ? {8'h0, got[0], got[1], got[2]} : 32'hX, 32'h0055_6677);
        card_tx_ready = 1'b1;
        #1;
        chk(!card_tx_valid, "R5 no byte past count", 32'(card_tx_valid), 32'd0);
        card_tx_ready = 1'b0;
        chk(data_done && prog_done && !active, "R6 write done flags", {active, data_done, prog_done}, 32'h3);
        cpu_rd(S_STAT, 2'd2, rd);
        chk(rd == 32'h0000_1800, "R6 status bits", rd, 32'h0000_1800);
        chk(tx_req, "R7 request held after done", 32'(tx_req), 32'd1);
        cpu_wr(S_TX, 2'd0, 32'h0);
        chk(!tx_req, "R7 cleared by transmit write", 32'(tx_req), 32'd0);

        // R2 random widths overfilling the queue, then random-ready drain
        cpu_wr(S_BLKLEN, 2'd2, 32'd32);
        cpu_wr(S_NUMBLK, 2'd2, 32'd1);
        start_xfer();
        txm.delete();
        for (int att = 0; att < 44; ) begin
            logic [1:0]  code = 2'($urandom % 3);
            logic [31:0] d    = $urandom;
            tx_model(code, d);
            cpu_wr(S_TX, code, d);
            att += nb(code);
        end
        drain(32, 1'b1);
        chk(got.size() == 32, "R2 queue capped at 32", got.size(), 32);
        for (int i = 0; i < 32 && i < got.size(); i++)
            chk(got[i] == txm[i], "R2 random byte", 32'(got[i]), 32'(txm[i]));
        chk(data_done && prog_done, "R6 done after random fill", {data_done, prog_done}, 32'h3);

        // R9 partial-buffer command
        cpu_wr(S_BLKLEN, 2'd2, 32'd8);
        start_xfer();
        cpu_wr(S_TX, 2'd2, 32'h0102_0304);
        cpu_wr(S_PART, 2'd2, 32'h0000_0002);
        chk(card_tx_valid, "R9 bit0 clear has no effect", 32'(card_tx_valid), 32'd1);
        cpu_wr(S_PART, 2'd2, 32'h0000_0001);
        chk(!card_tx_valid, "R9 queue discarded", 32'(card_tx_valid), 32'd0);
        cpu_wr(S_TX, 2'd2, 32'hAABB_CCDD);
        cpu_wr(S_TX, 2'd0, 32'h0000_0099);
        drain(5, 1'b0);
        chk(got.size() == 5 && got[0] == 8'hAA && got[3] == 8'hDD && got[4] == 8'h99, "R9 new half order",
            got.size() == 5 ? {got[0], got[3], got[4], 8'h0} : 32'hX, 32'hAADD_9900);

        // R3 R4 R8 receive direction, 40 bytes
        cpu_wr(S_CTRL, 2'd2, 32'h0);
        cpu_wr(S_BLKLEN, 2'd2, 32'd20);
        cpu_wr(S_NUMBLK, 2'd2, 32'd2);
        start_xfer();
        rxm.delete();
        rx_total = 0;
        next_rx = 8'h40;
        chk(!card_tx_valid, "R11 transmit idle in read", 32'(card_tx_valid), 32'd0);
        feed(35);
        chk(rx_total == 32, "R4 ring holds 32", rx_total, 32);
        chk(!card_rx_ready && active, "R4 ready low when full", {card_rx_ready, active}, 32'h1);
        chk(rx_req, "R8 request on arrival", 32'(rx_req), 32'd1);
        cpu_rd(S_RX, 2'd2, rd);
        chk(rd == rx_model(2'd2), "R3 four-byte read", rd, 32'h4041_4243);
        cpu_rd(S_RX, 2'd1, rd);
        chk(rd == rx_model(2'd1), "R3 two-byte read", rd, 32'h0000_4445);
        chk(!rx_req, "R8 cleared by read", 32'(rx_req), 32'd0);
        cpu_rd(S_RX, 2'd0, rd);
        chk(rd == rx_model(2'd0), "R3 one-byte read", rd, 32'h0000_0046);
        for (int i = 0; i < 10; i++) begin
            logic [1:0]  code = 2'($urandom % 4);
            logic [31:0] e;
            cpu_rd(S_RX, code, rd);
            e = rx_model(code);
            chk(rd == e, "R3 random read", rd, e);
        end
        feed(20);
        chk(rx_total == 40, "R5 exact byte count", rx_total, 40);
        chk(!card_rx_ready, "R5 no accept past count", 32'(card_rx_ready), 32'd0);
        chk(data_done && !prog_done && !active, "R6 read done, no program done",
            {active, data_done, prog_done}, 32'h2);
        while (rxm.size() > 0) begin
            logic [1:0]  code = 2'($urandom % 3);
            logic [31:0] e;
            cpu_rd(S_RX, code, rd);
            e = rx_model(code);
            chk(rd == e, "R3 drain with zero lanes", rd, e);
        end
        cpu_rd(S_RX, 2'd2, rd);
        chk(rd == 32'd0, "R3 empty read zero", rd, 32'd0);

        // R5 R6 zero total
        cpu_wr(S_BLKLEN, 2'd2, 32'd0);
        start_xfer();
        chk(!card_rx_ready, "R5 zero total accepts nothing", 32'(card_rx_ready), 32'd0);
        @(negedge clk);
        chk(data_done && !active, "R6 zero total completes", {active, data_done}, 32'h1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule